// File: doc/BRIEF.md
# Composite Fault-Value Gate Evaluator

This block evaluates one logic gate in a five-valued algebra used for tracing stuck-at faults. Each net value carries what the net does in the fault-free circuit and in the faulty circuit at once, plus a flag saying whether the value is known at all. Besides plain 0 and 1, a known value can be D (fault-free 1, faulty 0) or its complement D-bar (fault-free 0, faulty 1). An unknown value, X, may later turn out to be any of the other four.

A test-generation engine gives the block a gate-type code, the number of inputs in use and up to four encoded input values. The block returns the encoded output value at once, with no clock. It also reports the gate's controlling and enabling input values, and whether one of the active inputs holds the controlling value. The engine uses these when it picks objectives and moves the propagation front. The block is purely combinational.

Top module: `comp_gate_eval`

## Requirements
- R1: Each value is 3 bits: bit 2 is the known flag, bit 1 the fault-free bit and bit 0 the faulty bit. D is 3'b110, D-bar is 3'b101, 0 is 3'b100 and 1 is 3'b111. Any value with bit 2 clear is X, whatever its other bits. The output always shows X as exactly 3'b000.
- R2: The gate codes are 0 AND, 1 NAND, 2 OR, 3 NOR, 4 NOT and 5 BUF. Codes 6 and 7 give an X output, and `forced`, `has_ctrl`, `ctrl_bit` and `enab_bit` are all 0.
- R3: For AND and NAND, `has_ctrl`=1, `ctrl_bit`=0 and `enab_bit`=1. For OR and NOR, `has_ctrl`=1, `ctrl_bit`=1 and `enab_bit`=0. For NOT and BUF, all three are 0.
- R4: An active input that is known, with both bits equal to the controlling value, forces the output even when other inputs are X: AND gives 0, NAND gives 1, OR gives 1 and NOR gives 0. `forced` is 1 in that case and 0 otherwise.
- R5: With no controlling input, any active X input makes the output X.
- R6: With all active inputs known and none controlling, the fault-free output bit is the gate function of the fault-free input bits, and the faulty output bit is the gate function of the faulty input bits. So D or D-bar passes through a gate whose other inputs hold the enabling value, inverted by NAND and NOR.
- R7: D together with D-bar gives 0 at an AND and 1 at an OR.
- R8: For the four multi-input gates, `fanin` + 1 inputs are active, starting at input 0. The inactive inputs behave as the enabling value, so an X or controlling value on them has no effect.
- R9: NOT and BUF look only at input 0. BUF copies it, NOT inverts both bits, and an X input gives an X output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gate_op | input | 3 | Gate-type code (R2) |
| fanin | input | 2 | Number of active inputs minus one |
| in_vals | input | 12 | Input values; input k sits in bits 3k+2 down to 3k |
| out_val | output | 3 | Encoded output value |
| forced | output | 1 | An active input holds the controlling value |
| has_ctrl | output | 1 | The gate type has a controlling value |
| ctrl_bit | output | 1 | The controlling input value |
| enab_bit | output | 1 | The enabling input value |

## Verification
The assertions assume only that every input bit is driven to 0 or 1. While any input is unknown they check nothing, because the block has no reset to give it a defined state. The stimulus drives every bit from the start. It mixes X inputs whose lower bits hold both zeros and nonzero patterns, and it covers all eight gate codes and every fan-in count. So all input patterns appear, including the reserved codes and the non-canonical unknowns.

// File: rtl/comp_gate_eval.sv
module comp_gate_eval #(
  parameter int NUM_IN = 4,
  localparam int SELW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int VW = 3
) (
  input  logic [2:0]           gate_op,
  input  logic [SELW-1:0]      fanin,
  input  logic [NUM_IN*VW-1:0] in_vals,
  output logic [VW-1:0]        out_val,
  output logic                 forced,
  output logic                 has_ctrl,
  output logic                 ctrl_bit,
  output logic                 enab_bit
);
  localparam logic [2:0] OP_AND  = 3'd0;
  localparam logic [2:0] OP_NAND = 3'd1;
  localparam logic [2:0] OP_OR   = 3'd2;
  localparam logic [2:0] OP_NOR  = 3'd3;
  localparam logic [2:0] OP_NOT  = 3'd4;
  localparam logic [2:0] OP_BUF  = 3'd5;

  logic is_andf, is_orf, is_unary, inv_out;
  logic [NUM_IN-1:0] act, kn, gd, fl, hit;
  logic any_x, base_g, base_f, res;

  assign is_andf  = (gate_op == OP_AND) || (gate_op == OP_NAND);
  assign is_orf   = (gate_op == OP_OR)  || (gate_op == OP_NOR);
  assign is_unary = (gate_op == OP_NOT) || (gate_op == OP_BUF);
  assign inv_out  = (gate_op == OP_NAND) || (gate_op == OP_NOR) || (gate_op == OP_NOT);

  assign has_ctrl = is_andf | is_orf;
  assign ctrl_bit = is_orf;
  assign enab_bit = is_andf;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    if (i == 0) begin : g_first
      assign act[i] = 1'b1;
    end else begin : g_rest
      assign act[i] = !is_unary && (int'(fanin) >= i);
    end
    assign kn[i]  = in_vals[VW*i+2] | ~act[i];
    assign gd[i]  = act[i] ? in_vals[VW*i+1] : enab_bit;
    assign fl[i]  = act[i] ? in_vals[VW*i]   : enab_bit;
    assign hit[i] = has_ctrl & act[i] & in_vals[VW*i+2]
                  & (in_vals[VW*i+1] == ctrl_bit) & (in_vals[VW*i] == ctrl_bit);
  end

  assign forced = |hit;
  assign any_x  = ~&kn;
  assign base_g = is_orf ? |gd : (is_andf ? &gd : gd[0]);
  assign base_f = is_orf ? |fl : (is_andf ? &fl : fl[0]);
  assign res    = ctrl_bit ^ inv_out;

  always_comb begin
    if (!(has_ctrl | is_unary))
      out_val = '0;
    else if (forced)
      out_val = {1'b1, res, res};
    else if (any_x)
      out_val = '0;
    else
      out_val = {1'b1, base_g ^ inv_out, base_f ^ inv_out};
  end
endmodule

// File: rtl/comp_gate_eval_chk.sv
module comp_gate_eval_chk #(
  parameter int NUM_IN = 4,
  localparam int SELW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input logic [2:0]          gate_op,
  input logic [SELW-1:0]     fanin,
  input logic [NUM_IN*3-1:0] in_vals,
  input logic [2:0]          out_val,
  input logic                forced,
  input logic                has_ctrl,
  input logic                ctrl_bit,
  input logic                enab_bit
);
  always_comb begin
    if (!$isunknown({gate_op, fanin, in_vals, out_val, forced, has_ctrl, ctrl_bit, enab_bit})) begin
      p_x_canonical_r1: assert (out_val[2] || out_val == 3'b000);
      p_reserved_x_r2: assert (gate_op < 3'd6 || (out_val == 3'b000 && !has_ctrl && !forced));
      p_flags_pair_r3: assert (!has_ctrl || (ctrl_bit != enab_bit));
      p_forced_known_r4: assert (!forced || (out_val[2] && out_val[1] == out_val[0]));
      p_forced_needs_ctrl_r4: assert (!forced || has_ctrl);
      p_unary_x_r9: assert (!(gate_op == 3'd4 || gate_op == 3'd5) || (out_val[2] == in_vals[2]));
    end
  end
endmodule

bind comp_gate_eval comp_gate_eval_chk #(.NUM_IN(NUM_IN)) u_chk (
  .gate_op(gate_op), .fanin(fanin), .in_vals(in_vals), .out_val(out_val),
  .forced(forced), .has_ctrl(has_ctrl), .ctrl_bit(ctrl_bit), .enab_bit(enab_bit)
);

// File: tb/comp_gate_eval_test.sv
module comp_gate_eval_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] V0 = 3'b100, V1 = 3'b111, VD = 3'b110, VDB = 3'b101, VX = 3'b000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] gate_op = '0;
  logic [1:0] fanin = '0;
  logic [11:0] in_vals = '0;
  logic [2:0] out_val;
  logic forced, has_ctrl, ctrl_bit, enab_bit;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comp_gate_eval uut (
    .gate_op(gate_op), .fanin(fanin), .in_vals(in_vals), .out_val(out_val),
    .forced(forced), .has_ctrl(has_ctrl), .ctrl_bit(ctrl_bit), .enab_bit(enab_bit)
  );

  // returns {has_ctrl, ctrl_bit, enab_bit, forced, out[2:0]}
  function automatic logic [6:0] ref_eval(logic [2:0] op, logic [1:0] fan, logic [11:0] v);
    logic andf, orf, un, inv, cv, frc, anyx, g, f;
    logic [2:0] vk, o;
    int n;
    andf = (op == 3'd0) || (op == 3'd1);
    orf  = (op == 3'd2) || (op == 3'd3);
    un   = (op == 3'd4) || (op == 3'd5);
    inv  = (op == 3'd1) || (op == 3'd3) || (op == 3'd4);
    cv = orf; frc = 0; anyx = 0; g = andf; f = andf;
    n = un ? 1 : int'(fan) + 1;
    if (un) begin
      g = v[1]; f = v[0]; anyx = !v[2];
    end else begin
      for (int k = 0; k < n; k++) begin
        vk = v[3*k +: 3];
        if (!vk[2]) anyx = 1;
        else if ((andf || orf) && vk[1] == cv && vk[0] == cv) frc = 1;
        if (andf) begin g = g & vk[1]; f = f & vk[0]; end
        else begin g = g | vk[1]; f = f | vk[0]; end
      end
    end
    if (!(andf || orf || un)) o = VX;
    else if (frc) o = {1'b1, cv ^ inv, cv ^ inv};
    else if (anyx) o = VX;
    else o = {1'b1, g ^ inv, f ^ inv};
    return {andf || orf, orf, andf, frc, o};
  endfunction

  task automatic chk(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d fan=%0d in=%h got=%b exp=%b", tag, gate_op, fanin, in_vals, got, exp);
    end
  endtask

  task automatic apply(string tag, logic [2:0] op, logic [1:0] fan, logic [11:0] v);
    @(posedge clk);
    gate_op = op; fanin = fan; in_vals = v;
    @(negedge clk);
    chk(tag, {has_ctrl, ctrl_bit, enab_bit, forced, out_val}, ref_eval(op, fan, v));
  endtask

  task automatic apply_exp(string tag, logic [2:0] op, logic [1:0] fan, logic [11:0] v, logic [2:0] e);
    apply(tag, op, fan, v);
    checks++;
    if (out_val !== e) begin
      errors++;
      $display("FAIL %s out got=%b exp=%b", tag, out_val, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] rop;
    logic [11:0] rv;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {has_ctrl, ctrl_bit, enab_bit, forced, out_val}, 7'b1010000);
    apply_exp("R6 D through AND", 3'd0, 2'd3, {V1, V1, V1, VD}, VD);
    apply_exp("R6 D inverted by NAND", 3'd1, 2'd1, {VX, VX, V1, VD}, VDB);
    apply_exp("R6 DB through NOR", 3'd3, 2'd2, {VX, V0, VDB, V0}, VD);
    apply_exp("R7 D and DB at AND", 3'd0, 2'd1, {V1, V1, VDB, VD}, V0);
    apply_exp("R7 D and DB at OR", 3'd2, 2'd1, {V0, V0, VDB, VD}, V1);
    apply_exp("R4 AND forced over X", 3'd0, 2'd3, {VX, V0, VX, VD}, V0);
    apply_exp("R4 NOR forced over X", 3'd3, 2'd2, {V0, VX, V1, VX}, V0);
    apply_exp("R4 NAND forced", 3'd1, 2'd2, {VX, V0, V1, V1}, V1);
    apply_exp("R5 X without control", 3'd2, 2'd2, {V1, 3'b011, VD, V0}, VX);
    apply_exp("R1 noncanonical X", 3'd4, 2'd0, {9'b0, 3'b011}, VX);
    apply_exp("R8 inactive X ignored", 3'd0, 2'd1, {VX, VX, V1, VD}, VD);
    apply_exp("R8 inactive control ignored", 3'd2, 2'd0, {V1, V1, V1, VDB}, VDB);
    apply_exp("R9 NOT of D", 3'd4, 2'd3, {V0, V0, V0, VD}, VDB);
    apply_exp("R9 BUF of X", 3'd5, 2'd3, {V1, V1, V1, VX}, VX);
    apply_exp("R2 reserved code 6", 3'd6, 2'd3, {V1, V1, V1, V1}, VX);
    apply_exp("R2 reserved code 7", 3'd7, 2'd0, {V0, V0, V0, V0}, VX);
    apply("R3 flags OR", 3'd2, 2'd0, {V0, V0, V0, V0});
    apply("R3 flags NOT", 3'd4, 2'd0, {V0, V0, V0, V0});
    void'($urandom(32'h5eed_0c4f));
    for (int t = 0; t < 3000; t++) begin
      rop = 3'($urandom_range(0, 7));
      rv = 12'($urandom);
      if (($urandom & 3) != 0)
        for (int k = 0; k < 4; k++) if (!rv[3*k+2] && ($urandom & 1)) rv[3*k+2] = 1'b1;
      apply("R6 random", rop, 2'($urandom), rv);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule